// File: doc/BRIEF.md
# Microcode Loader for an Embedded Controller

This block connects a byte-wide host register port to the program RAM of an embedded controller. The host frames every transaction as a command byte, an address byte and then any number of data bytes, and closes it with an end strobe. When the address byte names the microcode port, the loader holds the controller in reset and rewinds its own RAM pointer to location zero. It then streams data bytes into the RAM, or returns RAM contents one byte per data phase, and the pointer advances by one on each byte.

The controller stays in reset after the microcode transaction closes. A write transaction to the release register lets it run again, and the data byte of that write is ignored. All other addresses go to a generic register-file port and leave the loader state alone. Reads are prefetched from a synchronous RAM port, so the byte for the next data phase is already waiting when the host asks for it. A host access past the end of the RAM is dropped and raises a sticky overflow flag.

Top module: `ucode_loader`

## Requirements
- R1: After the active-low hard reset `rstN`, `cpuReset`, `loaderBusy` and `overflow` are all 0 and no transaction is open. Asserting `rstN` in the middle of a transaction returns the block to this state.
- R2: Framing. The first byte after an end strobe (or after reset) is the command byte, and bit 0 of it selects the direction: 1 is a read, 0 is a write. The second byte is the address. Every later byte is a data byte. A `hostEnd` pulse closes the transaction in any phase.
- R3: An address byte equal to `UCODE_ADDR` (default 0x7E) opens a microcode access in either direction. From the next cycle, `cpuReset` and `loaderBusy` are 1, and the pointer is at location 0.
- R4: In a microcode write, the data bytes are stored at RAM locations 0, 1, 2, and so on, in the order they arrive.
- R5: In a microcode read, `hostRdData` shows location 0 from the second cycle after the address byte. After each data byte the host sends as an acknowledge, `hostRdData` shows the next location from the second cycle after that byte.
- R6: `loaderBusy` falls the cycle after `hostEnd`. `cpuReset` stays at 1 after a microcode transaction ends.
- R7: A write transaction to `RELEASE_ADDR` (default 0x7F) clears `cpuReset` the cycle after its first data byte, whatever the value of that byte. A read of that address does not clear `cpuReset`.
- R8: Any other address is passed to the register-file port. `regStrobe` pulses with each data byte, `regAddr` holds the address byte, and on reads `hostRdData` follows `regRdata`. Such a transaction changes neither `cpuReset` nor the RAM nor the pointer.
- R9: When the pointer has reached `DEPTH`, a further write byte is not stored and the pointer saturates. A read at that position returns 0x00. In both cases the access sets `overflow`. `overflow` clears only on hard reset or when the next microcode access opens.
- R10: Every new microcode access restarts at location 0, wherever the previous one stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low hard reset |
| hostValid | input | 1 | A host byte is present this cycle |
| hostByte | input | 8 | Host byte: command, address or write data |
| hostEnd | input | 1 | Closes the current transaction |
| hostRdData | output | 8 | Byte returned for the current read data phase |
| regStrobe | output | 1 | Register-file access strobe, one per data byte |
| regWrite | output | 1 | Register-file direction (1 = write) |
| regAddr | output | 8 | Register-file address |
| regWdata | output | 8 | Register-file write data |
| regRdata | input | 8 | Register-file read data |
| ramEn | output | 1 | Program RAM access enable |
| ramWe | output | 1 | Program RAM write enable |
| ramAddr | output | $clog2(DEPTH) | Program RAM address |
| ramWdata | output | 8 | Program RAM write data |
| ramRdata | input | 8 | Program RAM read data, one cycle after the access |
| cpuReset | output | 1 | Holds the embedded controller in reset |
| loaderBusy | output | 1 | A microcode access is open |
| overflow | output | 1 | Sticky flag: an access ran past the last RAM location |

## Verification
A pointer that is off by one, or that does not rewind, shows up on `ramAddr` at the first data byte of a write. It also shows up on `hostRdData` two cycles after the first read acknowledge, because each readback byte is compared against an independent shadow copy of what was written. A reset flag stuck in the wrong state is visible on `cpuReset` one cycle after the address byte that opens an access, or one cycle after the release byte. That check is repeated around register-file traffic and release-register reads. A wrong saturation boundary appears on `overflow` at the access one past `DEPTH`, and as a corrupted last location in the readback that follows.

// File: rtl/ucode_loader_pkg.sv
package ucode_loader_pkg;

  localparam int BYTE_W = 8;

  // Position inside a host transaction.
  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_t;

  // What the address byte selected.
  typedef enum logic [1:0] {
    TGT_NONE    = 2'd0,
    TGT_UCODE   = 2'd1,
    TGT_RELEASE = 2'd2,
    TGT_REG     = 2'd3
  } target_t;

  // Control -> datapath strobes.
  typedef struct packed {
    logic rewind;     // pointer to zero
    logic advance;    // pointer + 1
    logic write;      // store host byte at pointer
    logic readIssue;  // fetch next location (or location 0 with rewind)
    logic ovfSet;     // access past the end
    logic ovfClr;     // new microcode access opened
    logic selReg;     // read data comes from the register file
  } loadStrobe_t;

endpackage

// File: rtl/ucode_loader_ctrl.sv
module ucode_loader_ctrl
  import ucode_loader_pkg::*;
#(
  parameter logic [BYTE_W-1:0] UCODE_ADDR   = 8'h7E,
  parameter logic [BYTE_W-1:0] RELEASE_ADDR = 8'h7F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostValid,
  input  logic [BYTE_W-1:0] hostByte,
  input  logic              hostEnd,
  input  logic              atEnd,
  output loadStrobe_t       stb,
  output logic              regStrobe,
  output logic              regWrite,
  output logic [BYTE_W-1:0] regAddr,
  output logic              cpuReset,
  output logic              loaderBusy
);

  phase_t  phase;
  target_t target;
  logic    isRead;
  logic    byteIn;

  assign byteIn = hostValid && !hostEnd;

  // Strobes for the datapath and the register-file port.
  always_comb begin
    stb        = '0;
    stb.selReg = (target == TGT_REG);
    regStrobe  = 1'b0;
    regWrite   = !isRead;
    if (byteIn) begin
      case (phase)
        PH_ADDR: begin
          if (hostByte == UCODE_ADDR) begin
            stb.rewind    = 1'b1;
            stb.ovfClr    = 1'b1;
            stb.readIssue = isRead;
          end
        end
        PH_DATA: begin
          case (target)
            TGT_UCODE: begin
              if (atEnd) begin
                stb.ovfSet = 1'b1;
              end else begin
                stb.advance   = 1'b1;
                stb.write     = !isRead;
                stb.readIssue = isRead;
              end
            end
            TGT_REG:  regStrobe = 1'b1;
            default:  ;
          endcase
        end
        default: ;
      endcase
    end
  end

  // Phase tracking, address decode and the reset-hold flag.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase      <= PH_CMD;
      target     <= TGT_NONE;
      isRead     <= 1'b0;
      regAddr    <= '0;
      cpuReset   <= 1'b0;
      loaderBusy <= 1'b0;
    end else if (hostEnd) begin
      phase      <= PH_CMD;
      target     <= TGT_NONE;
      loaderBusy <= 1'b0;
    end else if (hostValid) begin
      case (phase)
        PH_CMD: begin
          isRead <= hostByte[0];
          phase  <= PH_ADDR;
        end
        PH_ADDR: begin
          regAddr <= hostByte;
          phase   <= PH_DATA;
          if (hostByte == UCODE_ADDR) begin
            target     <= TGT_UCODE;
            cpuReset   <= 1'b1;
            loaderBusy <= 1'b1;
          end else if (hostByte == RELEASE_ADDR && !isRead) begin
            target <= TGT_RELEASE;
          end else begin
            target <= TGT_REG;
          end
        end
        PH_DATA: begin
          if (target == TGT_RELEASE) cpuReset <= 1'b0;
        end
        default: phase <= PH_CMD;
      endcase
    end
  end

endmodule

// File: rtl/ucode_loader_dp.sv
module ucode_loader_dp
  import ucode_loader_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  loadStrobe_t       stb,
  input  logic [BYTE_W-1:0] ramRdata,
  input  logic [BYTE_W-1:0] regRdata,
  output logic              atEnd,
  output logic              ramEn,
  output logic              ramWe,
  output logic [AW-1:0]     ramAddr,
  output logic [BYTE_W-1:0] hostRdData,
  output logic              overflow
);

  localparam logic [AW:0] DEPTH_V = (AW + 1)'(DEPTH);

  logic [AW:0]       ptr;
  logic [AW:0]       ptrInc;
  logic              nextInRange;
  logic              rdPend;
  logic              rdBlank;
  logic [BYTE_W-1:0] rdHold;

  assign ptrInc      = ptr + 1'b1;
  assign atEnd       = (ptr == DEPTH_V);
  assign nextInRange = stb.rewind || (ptrInc != DEPTH_V);

  // RAM request: writes use the current pointer, reads prefetch the next one.
  assign ramWe   = stb.write;
  assign ramEn   = stb.write || (stb.readIssue && nextInRange);
  assign ramAddr = stb.write  ? ptr[AW-1:0]
                 : stb.rewind ? '0
                 : ptrInc[AW-1:0];

  assign hostRdData = stb.selReg ? regRdata : rdHold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr      <= '0;
      rdPend   <= 1'b0;
      rdBlank  <= 1'b0;
      rdHold   <= '0;
      overflow <= 1'b0;
    end else begin
      if (stb.rewind)                ptr <= '0;
      else if (stb.advance && !atEnd) ptr <= ptrInc;

      rdPend  <= stb.readIssue && nextInRange;
      rdBlank <= stb.readIssue && !nextInRange;
      if (rdPend)       rdHold <= ramRdata;
      else if (rdBlank) rdHold <= '0;

      if (stb.ovfClr)      overflow <= 1'b0;
      else if (stb.ovfSet) overflow <= 1'b1;
    end
  end

endmodule

// File: rtl/ucode_loader.sv
module ucode_loader
  import ucode_loader_pkg::*;
#(
  parameter int                DEPTH        = 1024,
  parameter logic [BYTE_W-1:0] UCODE_ADDR   = 8'h7E,
  parameter logic [BYTE_W-1:0] RELEASE_ADDR = 8'h7F,
  localparam int               AW           = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostValid,
  input  logic [BYTE_W-1:0] hostByte,
  input  logic              hostEnd,
  output logic [BYTE_W-1:0] hostRdData,
  output logic              regStrobe,
  output logic              regWrite,
  output logic [BYTE_W-1:0] regAddr,
  output logic [BYTE_W-1:0] regWdata,
  input  logic [BYTE_W-1:0] regRdata,
  output logic              ramEn,
  output logic              ramWe,
  output logic [AW-1:0]     ramAddr,
  output logic [BYTE_W-1:0] ramWdata,
  input  logic [BYTE_W-1:0] ramRdata,
  output logic              cpuReset,
  output logic              loaderBusy,
  output logic              overflow
);

  loadStrobe_t stb;
  logic        atEnd;

  assign regWdata = hostByte;
  assign ramWdata = hostByte;

  ucode_loader_ctrl #(
    .UCODE_ADDR  (UCODE_ADDR),
    .RELEASE_ADDR(RELEASE_ADDR)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .hostValid (hostValid),
    .hostByte  (hostByte),
    .hostEnd   (hostEnd),
    .atEnd     (atEnd),
    .stb       (stb),
    .regStrobe (regStrobe),
    .regWrite  (regWrite),
    .regAddr   (regAddr),
    .cpuReset  (cpuReset),
    .loaderBusy(loaderBusy)
  );

  ucode_loader_dp #(
    .DEPTH(DEPTH),
    .AW   (AW)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .ramRdata  (ramRdata),
    .regRdata  (regRdata),
    .atEnd     (atEnd),
    .ramEn     (ramEn),
    .ramWe     (ramWe),
    .ramAddr   (ramAddr),
    .hostRdData(hostRdData),
    .overflow  (overflow)
  );

endmodule

// File: rtl/ucode_loader_chk.sv
module ucode_loader_chk (
  input logic clk,
  input logic rstN,
  input logic cpuReset,
  input logic loaderBusy,
  input logic overflow,
  input logic ramEn,
  input logic ramWe,
  input logic regStrobe
);

  // R1: leaving hard reset, all status outputs are low
  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!cpuReset && !loaderBusy && !overflow));

  // R3: an open microcode access always holds the controller in reset
  a_r3_busy_holds_reset: assert property (@(posedge clk) disable iff (!rstN)
    loaderBusy |-> cpuReset);

  // R4: RAM is written only inside an open microcode access
  a_r4_write_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> (ramEn && loaderBusy));

  // R7: release happens only outside a microcode access
  a_r7_release_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cpuReset) |-> !loaderBusy);

  // R8: register-file traffic never touches the RAM
  a_r8_reg_no_ram: assert property (@(posedge clk) disable iff (!rstN)
    regStrobe |-> !ramEn);

  // R9: overflow only clears when a new microcode access opens
  a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    $fell(overflow) |-> loaderBusy);

endmodule

bind ucode_loader ucode_loader_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cpuReset  (cpuReset),
  .loaderBusy(loaderBusy),
  .overflow  (overflow),
  .ramEn     (ramEn),
  .ramWe     (ramWe),
  .regStrobe (regStrobe)
);

// File: tb/ucode_loader_tb.sv
`timescale 1ns/1ps
module ucode_loader_tb;

  localparam int         DEPTH = 32;
  localparam int         AW    = $clog2(DEPTH);
  localparam logic [7:0] UC    = 8'h7E;
  localparam logic [7:0] REL   = 8'h7F;

  // {length, base, step, release value}
  localparam logic [31:0] VECS [4] = '{
    32'h01_A5_00_33,
    32'h08_00_01_00,
    32'h14_3C_1D_C7,
    32'h20_FF_0B_5A
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          hostValid = 1'b0;
  logic [7:0]    hostByte = '0;
  logic          hostEnd = 1'b0;
  logic [7:0]    hostRdData;
  logic          regStrobe, regWrite;
  logic [7:0]    regAddr, regWdata, regRdata;
  logic          ramEn, ramWe;
  logic [AW-1:0] ramAddr;
  logic [7:0]    ramWdata, ramRdata;
  logic          cpuReset, loaderBusy, overflow;

  int checks = 0;
  int failures = 0;

  logic [7:0] ram    [DEPTH];
  logic [7:0] regMem [256];
  logic [7:0] shadow [DEPTH];

  always #2.5 clk = ~clk;

  ucode_loader #(.DEPTH(DEPTH), .UCODE_ADDR(UC), .RELEASE_ADDR(REL)) u_dut (
    .clk(clk), .rstN(rstN), .hostValid(hostValid), .hostByte(hostByte),
    .hostEnd(hostEnd), .hostRdData(hostRdData), .regStrobe(regStrobe),
    .regWrite(regWrite), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .ramEn(ramEn), .ramWe(ramWe), .ramAddr(ramAddr),
    .ramWdata(ramWdata), .ramRdata(ramRdata), .cpuReset(cpuReset),
    .loaderBusy(loaderBusy), .overflow(overflow)
  );

  // Synchronous program RAM model, read-before-write.
  always_ff @(posedge clk) begin
    if (ramEn) begin
      if (ramWe) ram[ramAddr] <= ramWdata;
      ramRdata <= ram[ramAddr];
    end
  end

  // Register-file model.
  always_ff @(posedge clk) begin
    if (regStrobe && regWrite) regMem[regAddr] <= regWdata;
  end
  assign regRdata = regMem[regAddr];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk); hostByte = b; hostValid = 1'b1;
    @(negedge clk); hostValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic endTx();
    @(negedge clk); hostEnd = 1'b1;
    @(negedge clk); hostEnd = 1'b0;
    @(negedge clk);
  endtask

  task automatic openTx(input logic rd, input logic [7:0] addr);
    sendByte({7'b0, rd});
    sendByte(addr);
  endtask

  // Writes n bytes to an open microcode access; the shadow keeps what R4/R9 predict.
  task automatic ucodeWrite(input int n, input logic [7:0] base, input logic [7:0] step);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = base + 8'(i) * step;
      sendByte(b);
      if (i < DEPTH) shadow[i] = b;
    end
  endtask

  // Reads n bytes from an open microcode access, acknowledging each one.
  task automatic ucodeRead(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      check(req, hostRdData, (i < DEPTH) ? shadow[i] : 8'h00);
      sendByte(8'h00);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: state right after reset
    check("R1 cpuReset", cpuReset, 0);
    check("R1 loaderBusy", loaderBusy, 0);
    check("R1 overflow", overflow, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle after release", {cpuReset, loaderBusy, overflow}, 0);

    // Vector table: write, end, read back, release.
    for (int v = 0; v < 4; v++) begin
      int         len;
      logic [7:0] base, step, relv;
      len  = int'(VECS[v][31:24]);
      base = VECS[v][23:16];
      step = VECS[v][15:8];
      relv = VECS[v][7:0];
      openTx(1'b0, UC);
      check("R3 cpuReset on open", cpuReset, 1);
      check("R3 loaderBusy on open", loaderBusy, 1);
      ucodeWrite(len, base, step);
      endTx();
      check("R6 busy drops", loaderBusy, 0);
      check("R6 reset held", cpuReset, 1);
      openTx(1'b1, UC);
      ucodeRead(len, "R4 R5 readback");
      endTx();
      check("R9 no overflow within depth", overflow, 0);
      openTx(1'b0, REL);
      sendByte(relv);
      check("R7 release any value", cpuReset, 0);
      endTx();
    end

    // R2: transaction ended after the command byte; next one frames correctly.
    sendByte(8'h00);
    endTx();
    check("R2 abort leaves idle", {cpuReset, loaderBusy}, 0);
    openTx(1'b0, UC);
    check("R2 fresh frame opens", loaderBusy, 1);
    ucodeWrite(2, 8'h91, 8'h11);
    endTx();

    // R8: register traffic while held in reset.
    openTx(1'b0, 8'h10);
    sendByte(8'h5A);
    endTx();
    check("R8 reg write keeps reset", cpuReset, 1);
    openTx(1'b1, 8'h10);
    check("R8 reg readback", hostRdData, 8'h5A);
    check("R8 reg not busy", loaderBusy, 0);
    endTx();
    // R7: a read of the release address does not release.
    openTx(1'b1, REL);
    sendByte(8'h00);
    endTx();
    check("R7 read does not release", cpuReset, 1);
    openTx(1'b1, UC);
    ucodeRead(2, "R8 RAM untouched");
    endTx();

    // R10: a new access restarts at zero.
    openTx(1'b0, UC);
    ucodeWrite(3, 8'hAA, 8'h11);
    endTx();
    openTx(1'b0, UC);
    ucodeWrite(1, 8'h11, 8'h00);
    endTx();
    openTx(1'b1, UC);
    check("R10 loc0 rewritten", hostRdData, 8'h11);
    ucodeRead(3, "R10 rewind readback");
    endTx();

    // R9: write past the end.
    openTx(1'b0, UC);
    ucodeWrite(DEPTH + 1, 8'h40, 8'h01);
    check("R9 write overflow", overflow, 1);
    endTx();
    check("R9 overflow sticky", overflow, 1);
    openTx(1'b1, UC);
    check("R9 overflow clears on open", overflow, 0);
    ucodeRead(DEPTH, "R9 last location kept");
    check("R9 read past end data", hostRdData, 8'h00);
    check("R9 no overflow yet", overflow, 0);
    sendByte(8'h00);
    check("R9 read overflow", overflow, 1);
    endTx();

    // R1: hard reset in the middle of an open access.
    openTx(1'b0, UC);
    ucodeWrite(DEPTH + 1, 8'h07, 8'h03);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    check("R1 mid-access reset", {cpuReset, loaderBusy, overflow}, 0);
    rstN = 1'b1;
    @(negedge clk);
    openTx(1'b1, UC);
    ucodeRead(DEPTH, "R1 RAM readable after reset");
    endTx();

    summary();
    $finish;
  end

endmodule